// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block lets a synchronous on-chip host reach an external asynchronous static RAM of 128K bytes. The host raises a request together with a 17-bit address, a direction flag and (for stores) a data byte. The controller then sequences the RAM's control strobes and returns a one-cycle completion pulse, which carries the read byte for loads. The RAM side has an active-high enable, active-low select, write and output-enable strobes, a 17-bit address bus and a byte-wide data bus. The data bus is brought out as a driven value, a drive-enable and a sampled input, so that the pad ring can build the tri-state buffer.

Every analogue timing limit of the RAM is given as a nanosecond parameter. Each one is rounded up to whole clock cycles from a clock-period parameter, so the same RTL serves any clock. The address and write data are held for the whole store. The output-enable strobe is released before the controller drives the bus, and a fixed number of turnaround cycles lets the RAM's drivers reach high impedance first.

Top module: `sram_ctl`

## Requirements
- R1: While reset is low, and afterwards until a request is accepted, the select, write and output-enable strobes are high (inactive), the data drive-enable and the ready pulse are low, and the chip enable is low during reset and high from the first clock after reset.
- R2: A load drives chip enable high, select low, write strobe high and output enable low, and output enable is never low unless that full combination holds.
- R3: A load completes with ready exactly 2 + ACC + HZ clock edges after the request is first presented in idle, where ACC = ceil(max(25 ns, 9 ns) / period) and HZ = ceil(10 ns / period). The byte is sampled ACC + 1 cycles after the address and output enable change, and the read data output holds that byte until the next load completes.
- R4: A store holds the write strobe low for exactly WP = ceil(max(20 ns, 15 ns) / period) consecutive cycles, with select low and chip enable high throughout, and completes with ready 2 + WP + REC edges after the request is first presented in idle.
- R5: The address is driven one cycle before the write strobe falls, and it stays unchanged from then until the recovery ends. The write byte is driven from that same cycle and stays unchanged through the pulse, so it is stable at least 15 ns before the strobe rises.
- R6: Between two stores the write strobe stays high for at least REC + 1 cycles, where REC = ceil(5 ns / period), and never less than 5 ns.
- R7: The data drive-enable is never high while output enable is low. After a load releases output enable, the drive-enable stays low for at least HZ + 1 further cycles, so it never overlaps the RAM driving the bus.
- R8: A request is accepted only in idle while ready is low. A request held during reset, or a change of the host address, data or direction while an access is in progress, has no effect on what is stored.
- R9: In idle, select and output enable are high and the data drive-enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req | input | 1 | Access request, held until ready |
| host_wr | input | 1 | 1 = store, 0 = load |
| host_addr | input | 17 | Byte address |
| host_wdata | input | 8 | Store data |
| host_ready | output | 1 | One-cycle completion pulse |
| host_rdata | output | 8 | Registered load data |
| mem_addr | output | 17 | RAM address bus |
| mem_ce | output | 1 | RAM chip enable, active high |
| mem_cs_n | output | 1 | RAM select, active low |
| mem_we_n | output | 1 | RAM write strobe, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_dq_o | output | 8 | Value driven onto the data bus |
| mem_dq_oe | output | 1 | Data bus drive-enable |
| mem_dq_i | input | 8 | Value sampled from the data bus |

## Verification
The two functions that can collide are the end of a load, when the RAM still drives the bus while its drivers decay, and the start of the next store, when the controller begins to drive. The bench provokes this by issuing a store the moment a load's ready pulse is seen. A behavioural RAM model running on a sub-cycle tick keeps driving for 10 ns after output enable rises and flags any overlap with the controller's drive-enable. The bench also checks that the stored byte reads back and measures the cycle gap between the release of output enable and the start of the drive.

// File: rtl/sram_ctl_pkg.sv
`timescale 1ns/1ps
package sram_ctl_pkg;

   typedef enum logic [2:0] {
      ST_IDLE      = 3'd0,
      ST_RD_ACCESS = 3'd1,
      ST_RD_SAMPLE = 3'd2,
      ST_WR_SETUP  = 3'd3,
      ST_WR_PULSE  = 3'd4,
      ST_WR_RECOV  = 3'd5,
      ST_TURN      = 3'd6
   } ctl_state_e;

   function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned period);
      int unsigned c;
      c = (ns + period - 1) / period;
      return (c == 0) ? 1 : c;
   endfunction

   function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sram_ctl_timer.sv
`timescale 1ns/1ps
module sram_ctl_timer #(
   parameter int unsigned CW = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   output logic          expire
);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)          cnt_q <= '0;
      else if (load)       cnt_q <= load_val;
      else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
   end

   assign expire = (cnt_q == '0);

   // R4: an expired timer stays expired until it is reloaded
   a_r4_timer_rest: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == '0 && !load) |=> (cnt_q == '0));

endmodule

// File: rtl/sram_ctl_dpath.sv
`timescale 1ns/1ps
module sram_ctl_dpath #(
   parameter int unsigned AW = 17,
   parameter int unsigned DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          latch,
   input  logic          capture,
   input  logic [AW-1:0] host_addr,
   input  logic [DW-1:0] host_wdata,
   input  logic [DW-1:0] mem_dq_i,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_dq_o,
   output logic [DW-1:0] host_rdata
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mem_addr <= '0;
         mem_dq_o <= '0;
      end else if (latch) begin
         mem_addr <= host_addr;
         mem_dq_o <= host_wdata;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       host_rdata <= '0;
      else if (capture) host_rdata <= mem_dq_i;
   end

endmodule

// File: rtl/sram_ctl_fsm.sv
`timescale 1ns/1ps
module sram_ctl_fsm
   import sram_ctl_pkg::*;
#(
   parameter int unsigned CW      = 3,
   parameter int unsigned ACC_CYC = 3,
   parameter int unsigned WP_CYC  = 2,
   parameter int unsigned REC_CYC = 1,
   parameter int unsigned HZ_CYC  = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req,
   input  logic          wr,
   input  logic          tmr_expire,
   output logic          tmr_load,
   output logic [CW-1:0] tmr_val,
   output logic          latch,
   output logic          capture,
   output logic          ce,
   output logic          cs_n,
   output logic          oe_n,
   output logic          we_n,
   output logic          dq_oe,
   output logic          ready
);

   localparam int unsigned SU_CYC = 1;

   ctl_state_e st_q, st_d;

   always_comb begin
      st_d     = st_q;
      tmr_load = 1'b0;
      tmr_val  = '0;
      latch    = 1'b0;
      capture  = 1'b0;
      unique case (st_q)
         ST_IDLE: begin
            if (req && !ready) begin
               latch    = 1'b1;
               tmr_load = 1'b1;
               if (wr) begin
                  st_d    = ST_WR_SETUP;
                  tmr_val = CW'(SU_CYC - 1);
               end else begin
                  st_d    = ST_RD_ACCESS;
                  tmr_val = CW'(ACC_CYC - 1);
               end
            end
         end
         ST_RD_ACCESS: if (tmr_expire) st_d = ST_RD_SAMPLE;
         ST_RD_SAMPLE: begin
            capture  = 1'b1;
            st_d     = ST_TURN;
            tmr_load = 1'b1;
            tmr_val  = CW'(HZ_CYC - 1);
         end
         ST_TURN: if (tmr_expire) st_d = ST_IDLE;
         ST_WR_SETUP: begin
            if (tmr_expire) begin
               st_d     = ST_WR_PULSE;
               tmr_load = 1'b1;
               tmr_val  = CW'(WP_CYC - 1);
            end
         end
         ST_WR_PULSE: begin
            if (tmr_expire) begin
               st_d     = ST_WR_RECOV;
               tmr_load = 1'b1;
               tmr_val  = CW'(REC_CYC - 1);
            end
         end
         ST_WR_RECOV: if (tmr_expire) st_d = ST_IDLE;
         default: st_d = ST_IDLE;
      endcase
   end

   logic sel_d, rd_d, wp_d, drv_d;
   assign sel_d = (st_d == ST_RD_ACCESS) || (st_d == ST_RD_SAMPLE) ||
                  (st_d == ST_WR_SETUP)  || (st_d == ST_WR_PULSE)  ||
                  (st_d == ST_WR_RECOV);
   assign rd_d  = (st_d == ST_RD_ACCESS) || (st_d == ST_RD_SAMPLE);
   assign wp_d  = (st_d == ST_WR_PULSE);
   assign drv_d = (st_d == ST_WR_SETUP) || (st_d == ST_WR_PULSE) || (st_d == ST_WR_RECOV);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q  <= ST_IDLE;
         ce    <= 1'b0;
         cs_n  <= 1'b1;
         oe_n  <= 1'b1;
         we_n  <= 1'b1;
         dq_oe <= 1'b0;
         ready <= 1'b0;
      end else begin
         st_q  <= st_d;
         ce    <= 1'b1;
         cs_n  <= !sel_d;
         oe_n  <= !rd_d;
         we_n  <= !wp_d;
         dq_oe <= drv_d;
         ready <= (st_q != ST_IDLE) && (st_d == ST_IDLE);
      end
   end

   // checker-side count of write-strobe low cycles
   logic [CW:0] lo_run_q;
   always_ff @(posedge clk) begin
      if (!rst_n)     lo_run_q <= '0;
      else if (!we_n) lo_run_q <= lo_run_q + 1'b1;
      else            lo_run_q <= '0;
   end

   // checker-side count of cycles since output enable was released
   logic [CW+1:0] rel_run_q;
   always_ff @(posedge clk) begin
      if (!rst_n)                          rel_run_q <= '1;
      else if (!oe_n)                      rel_run_q <= '0;
      else if (rel_run_q != '1)            rel_run_q <= rel_run_q + 1'b1;
   end

   a_r2_read_combo: assert property (@(posedge clk) disable iff (!rst_n)
      !oe_n |-> (ce && !cs_n && we_n));

   a_r4_write_select: assert property (@(posedge clk) disable iff (!rst_n)
      !we_n |-> (ce && !cs_n && dq_oe));

   a_r4_pulse_len: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(we_n) |-> (lo_run_q == (CW+1)'(WP_CYC)));

   a_r7_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
      dq_oe |-> oe_n);

   a_r7_turn_gap: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dq_oe) |-> (rel_run_q > (CW+2)'(HZ_CYC)));

   a_r8_ready_single: assert property (@(posedge clk) disable iff (!rst_n)
      ready |=> !ready);

   a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_IDLE) |-> (cs_n && oe_n && !dq_oe));

endmodule

// File: rtl/sram_ctl.sv
`timescale 1ns/1ps
module sram_ctl
   import sram_ctl_pkg::*;
#(
   parameter int unsigned AW            = 17,
   parameter int unsigned DW            = 8,
   parameter int unsigned CLK_PERIOD_NS = 10,
   parameter int unsigned T_WP_NS       = 20,
   parameter int unsigned T_DS_NS       = 15,
   parameter int unsigned T_REC_NS      = 5,
   parameter int unsigned T_ACC_NS      = 25,
   parameter int unsigned T_OEA_NS      = 9,
   parameter int unsigned T_HZ_NS       = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          host_req,
   input  logic          host_wr,
   input  logic [AW-1:0] host_addr,
   input  logic [DW-1:0] host_wdata,
   output logic          host_ready,
   output logic [DW-1:0] host_rdata,
   output logic [AW-1:0] mem_addr,
   output logic          mem_ce,
   output logic          mem_cs_n,
   output logic          mem_we_n,
   output logic          mem_oe_n,
   output logic [DW-1:0] mem_dq_o,
   output logic          mem_dq_oe,
   input  logic [DW-1:0] mem_dq_i
);

   localparam int unsigned WP_CYC  = max_u(ns_to_cyc(T_WP_NS, CLK_PERIOD_NS),
                                           ns_to_cyc(T_DS_NS, CLK_PERIOD_NS));
   localparam int unsigned REC_CYC = ns_to_cyc(T_REC_NS, CLK_PERIOD_NS);
   localparam int unsigned ACC_CYC = max_u(ns_to_cyc(T_ACC_NS, CLK_PERIOD_NS),
                                           ns_to_cyc(T_OEA_NS, CLK_PERIOD_NS));
   localparam int unsigned HZ_CYC  = ns_to_cyc(T_HZ_NS, CLK_PERIOD_NS);
   localparam int unsigned MAX_CYC = max_u(max_u(WP_CYC, REC_CYC), max_u(ACC_CYC, HZ_CYC));
   localparam int unsigned CW      = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);

   if (CLK_PERIOD_NS == 0) begin : g_bad_period
      $error("sram_ctl: clock period must be non-zero");
   end
   if (AW < 1 || DW < 1) begin : g_bad_width
      $error("sram_ctl: bus widths must be non-zero");
   end

   logic          tmr_load, tmr_expire, latch, capture;
   logic [CW-1:0] tmr_val;

   sram_ctl_timer #(.CW(CW)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .expire   (tmr_expire)
   );

   sram_ctl_fsm #(
      .CW      (CW),
      .ACC_CYC (ACC_CYC),
      .WP_CYC  (WP_CYC),
      .REC_CYC (REC_CYC),
      .HZ_CYC  (HZ_CYC)
   ) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .req        (host_req),
      .wr         (host_wr),
      .tmr_expire (tmr_expire),
      .tmr_load   (tmr_load),
      .tmr_val    (tmr_val),
      .latch      (latch),
      .capture    (capture),
      .ce         (mem_ce),
      .cs_n       (mem_cs_n),
      .oe_n       (mem_oe_n),
      .we_n       (mem_we_n),
      .dq_oe      (mem_dq_oe),
      .ready      (host_ready)
   );

   sram_ctl_dpath #(.AW(AW), .DW(DW)) u_dpath (
      .clk        (clk),
      .rst_n      (rst_n),
      .latch      (latch),
      .capture    (capture),
      .host_addr  (host_addr),
      .host_wdata (host_wdata),
      .mem_dq_i   (mem_dq_i),
      .mem_addr   (mem_addr),
      .mem_dq_o   (mem_dq_o),
      .host_rdata (host_rdata)
   );

   a_r5_hold_in_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_we_n || $past(!mem_we_n)) |-> ($stable(mem_addr) && $stable(mem_dq_o)));

   a_r5_setup_before_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_we_n) |-> ($past(mem_dq_oe) && $past(!mem_cs_n)));

endmodule

// File: tb/sram_ctl_tb.sv
`timescale 1ns/1ps
module sram_ctl_tb;

   localparam int AW = 17;
   localparam int DW = 8;
   localparam int PER = 10;
   localparam realtime M_WP = 20.0, M_DS = 15.0, M_REC = 5.0;
   localparam realtime M_ACC = 25.0, M_OEA = 9.0, M_HZ = 10.0;

   function automatic int cdiv(input int ns);
      int c;
      c = (ns + PER - 1) / PER;
      return (c < 1) ? 1 : c;
   endfunction

   localparam int E_WP  = (cdiv(20) > cdiv(15)) ? cdiv(20) : cdiv(15);
   localparam int E_REC = cdiv(5);
   localparam int E_ACC = (cdiv(25) > cdiv(9)) ? cdiv(25) : cdiv(9);
   localparam int E_HZ  = cdiv(10);
   localparam int E_RLAT = 2 + E_ACC + E_HZ;
   localparam int E_WLAT = 2 + E_WP + E_REC;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          host_req, host_wr, host_ready;
   logic [AW-1:0] host_addr, mem_addr;
   logic [DW-1:0] host_wdata, host_rdata, mem_dq_o, mem_dq_i;
   logic          mem_ce, mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe;

   int nchk = 0;
   int nfail = 0;
   int nviol = 0;
   bit done = 1'b0;

   always #(PER/2) clk = ~clk;

   sram_ctl u_dut (
      .clk (clk), .rst_n (rst_n),
      .host_req (host_req), .host_wr (host_wr), .host_addr (host_addr),
      .host_wdata (host_wdata), .host_ready (host_ready), .host_rdata (host_rdata),
      .mem_addr (mem_addr), .mem_ce (mem_ce), .mem_cs_n (mem_cs_n),
      .mem_we_n (mem_we_n), .mem_oe_n (mem_oe_n), .mem_dq_o (mem_dq_o),
      .mem_dq_oe (mem_dq_oe), .mem_dq_i (mem_dq_i)
   );

   task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", rq, what, act, exp);
      end
   endtask

   // ---------------- behavioural RAM model (0.25 ns offset tick) -------------
   logic [7:0] ram [int unsigned];
   logic       drv = 1'b0;
   logic [7:0] ram_val = 8'hEE;

   assign mem_dq_i = drv ? ram_val : (mem_dq_oe ? mem_dq_o : 8'h00);

   task automatic viol(input string rq, input string what, input int act, input int exp);
      nviol++;
      chk(1'b0, rq, what, act, exp);
   endtask

   realtime t_addr = 0, t_oe = 0, t_dv = 0, t_ws = 0, t_wend = 0, t_rel = 0;
   logic [AW-1:0] p_addr = '0, w_addr = '0;
   logic [7:0]    p_dq = '0;
   bit p_oe_n = 1'b1, p_dqoe = 1'b0, w_act = 1'b0, seen_wr = 1'b0, p_rd = 1'b0;

   task automatic model_step();
      realtime now;
      bit sel, wnow, rd;
      now  = $realtime;
      sel  = mem_ce && !mem_cs_n;
      if (mem_addr != p_addr) t_addr = now;
      if (!mem_oe_n && p_oe_n) t_oe = now;
      if (mem_dq_oe && (!p_dqoe || mem_dq_o != p_dq)) t_dv = now;
      wnow = sel && !mem_we_n;
      if (wnow && !w_act) begin
         if (seen_wr && (now - t_wend) < M_REC) viol("R6", "write recovery ns", int'(now - t_wend), int'(M_REC));
         w_act = 1'b1; t_ws = now; w_addr = mem_addr;
      end
      if (w_act && wnow && mem_addr != w_addr) viol("R5", "address moved in pulse", int'(mem_addr), int'(w_addr));
      if (w_act && !wnow) begin
         if ((now - t_ws) < M_WP) viol("R4", "write pulse ns", int'(now - t_ws), int'(M_WP));
         if (!p_dqoe || (now - t_dv) < M_DS) viol("R5", "data setup ns", int'(now - t_dv), int'(M_DS));
         ram[w_addr] = p_dq;
         w_act = 1'b0; t_wend = now; seen_wr = 1'b1;
      end
      rd = sel && mem_we_n && !mem_oe_n;
      if (rd) begin
         drv = 1'b1;
         if ((now - t_addr) >= M_ACC && (now - t_oe) >= M_OEA)
            ram_val = ram.exists(mem_addr) ? ram[mem_addr] : 8'h00;
         else
            ram_val = 8'hEE;
      end else if (drv) begin
         if (p_rd) t_rel = now;
         ram_val = 8'hEE;
         if ((now - t_rel) >= M_HZ) drv = 1'b0;
      end
      if (drv && mem_dq_oe) viol("R7", "bus contention", 1, 0);
      p_addr = mem_addr; p_oe_n = mem_oe_n; p_dq = mem_dq_o; p_dqoe = mem_dq_oe; p_rd = rd;
   endtask

   initial begin
      #0.25;
      forever begin
         if (rst_n === 1'b1) model_step();
         #1;
      end
   end

   // ---------------- cycle monitor ----------------------------------------
   int lo_run = 0, last_pulse = 0, hi_run = 0, last_gap = 1000;
   int oe_run = 1000, last_turn = 1000;
   bit prev_we = 1'b1, prev_dqoe = 1'b0;
   always @(negedge clk) begin
      if (rst_n === 1'b1) begin
         if (!mem_we_n) begin
            if (prev_we) last_gap = hi_run;
            lo_run++;
         end else begin
            if (!prev_we) last_pulse = lo_run;
            lo_run = 0;
         end
         if (mem_we_n) hi_run++; else hi_run = 0;
         if (mem_oe_n) oe_run++; else oe_run = 0;
         if (mem_dq_oe && !prev_dqoe) last_turn = oe_run;
         prev_we = mem_we_n; prev_dqoe = mem_dq_oe;
      end
   end

   // ---------------- host tasks -------------------------------------------
   task automatic host_access(input bit w, input logic [AW-1:0] a, input logic [7:0] d,
                              output int lat, output logic [7:0] q);
      @(negedge clk);
      host_req = 1'b1; host_wr = w; host_addr = a; host_wdata = d;
      lat = 0;
      do begin
         @(negedge clk);
         lat++;
      end while (!host_ready && lat < 60);
      q = host_rdata;
      host_req = 1'b0;
   endtask

   task automatic t_write(input logic [AW-1:0] a, input logic [7:0] d);
      int lat; logic [7:0] q;
      host_access(1'b1, a, d, lat, q);
      chk(lat == E_WLAT, "R4", "store latency", lat, E_WLAT);
      chk(last_pulse == E_WP, "R4", "write strobe low cycles", last_pulse, E_WP);
   endtask

   task automatic t_read(input logic [AW-1:0] a, input logic [7:0] exp);
      int lat; logic [7:0] q;
      host_access(1'b0, a, 8'h00, lat, q);
      chk(lat == E_RLAT, "R3", "load latency", lat, E_RLAT);
      chk(q == exp, "R3", "load data", q, exp);
   endtask

   task automatic t_reset_state();
      chk(mem_cs_n && mem_oe_n && mem_we_n, "R1", "strobes idle in reset", {mem_cs_n, mem_oe_n, mem_we_n}, 3'b111);
      chk(!mem_dq_oe && !host_ready && !mem_ce, "R1", "drive/ready/ce low in reset", {mem_dq_oe, host_ready, mem_ce}, 0);
      @(negedge clk);
      rst_n = 1'b1; host_req = 1'b0;
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         chk(!host_ready && mem_cs_n && mem_we_n, "R8", "no access from reset-time request",
             {host_ready, mem_cs_n, mem_we_n}, 3'b011);
      end
      chk(mem_ce == 1'b1, "R1", "chip enable after reset", mem_ce, 1);
      t_read(17'h00005, 8'h00);
   endtask

   task automatic t_patterns();
      t_write(17'h00012, 8'hA5);
      t_write(17'h00000, 8'h00);
      t_write(17'h1FFFF, 8'hFF);
      t_write(17'h0AAAA, 8'h5A);
      t_read(17'h00012, 8'hA5);
      t_read(17'h1FFFF, 8'hFF);
      t_read(17'h00000, 8'h00);
      t_read(17'h0AAAA, 8'h5A);
   endtask

   task automatic t_back_to_back();
      t_write(17'h00100, 8'h11);
      t_write(17'h00101, 8'h22);
      chk(last_gap >= E_REC + 1, "R6", "strobe high cycles between stores", last_gap, E_REC + 1);
      t_read(17'h00100, 8'h11);
      t_read(17'h00101, 8'h22);
   endtask

   task automatic t_read_then_write();
      int v0;
      v0 = nviol;
      t_read(17'h00012, 8'hA5);
      t_write(17'h00012, 8'h3C);
      chk(last_turn >= E_HZ + 2, "R7", "cycles from output-enable release to drive", last_turn, E_HZ + 2);
      chk(nviol == v0, "R7", "model contention count", nviol - v0, 0);
      t_read(17'h00012, 8'h3C);
   endtask

   task automatic t_busy_ignore();
      int lat;
      @(negedge clk);
      host_req = 1'b1; host_wr = 1'b1; host_addr = 17'h00200; host_wdata = 8'h96;
      @(negedge clk);
      host_addr = 17'h00201; host_wdata = 8'h69; host_wr = 1'b0;
      lat = 1;
      while (!host_ready && lat < 60) begin @(negedge clk); lat++; end
      host_req = 1'b0;
      chk(lat == E_WLAT, "R8", "store latency with changing inputs", lat, E_WLAT);
      @(negedge clk);
      chk(!host_ready, "R8", "ready is a single cycle", host_ready, 0);
      t_read(17'h00200, 8'h96);
      t_read(17'h00201, 8'h00);
   endtask

   task automatic t_hold_and_idle();
      t_read(17'h1FFFF, 8'hFF);
      t_write(17'h00300, 8'h77);
      repeat (3) @(negedge clk);
      chk(host_rdata == 8'hFF, "R3", "read data held across store", host_rdata, 8'hFF);
      chk(mem_cs_n && mem_oe_n && !mem_dq_oe, "R9", "idle outputs", {mem_cs_n, mem_oe_n, mem_dq_oe}, 3'b110);
   endtask

   // R2: strobe combination observed during a load
   task automatic t_read_combo();
      int seen;
      seen = 0;
      @(negedge clk);
      host_req = 1'b1; host_wr = 1'b0; host_addr = 17'h00300;
      for (int i = 0; i < E_RLAT + 1; i++) begin
         @(negedge clk);
         if (!mem_oe_n) begin
            seen++;
            chk(mem_ce && !mem_cs_n && mem_we_n, "R2", "load strobe set", {mem_ce, mem_cs_n, mem_we_n}, 3'b101);
         end
         if (host_ready) host_req = 1'b0;
      end
      host_req = 1'b0;
      chk(seen == E_ACC + 1, "R2", "output-enable low cycles", seen, E_ACC + 1);
   endtask

   initial begin
      int wd;
      wd = 0;
      while (!done && wd < 100000) begin @(posedge clk); wd++; end
      if (!done) begin
         chk(1'b0, "R1", "watchdog expired", wd, 0);
         $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0;
      host_req = 1'b1; host_wr = 1'b1; host_addr = 17'h00005; host_wdata = 8'hA5;
      repeat (3) @(negedge clk);
      t_reset_state();
      t_patterns();
      t_back_to_back();
      t_read_then_write();
      t_busy_ignore();
      t_read_combo();
      t_hold_and_idle();
      repeat (4) @(negedge clk);
      chk(nviol == 0, "R5", "model protocol violations", nviol, 0);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end

endmodule